// File: doc/BRIEF.md
# Device Enumeration Table Responder

This block is a read-only register window through which host software discovers the sub-modules built into an FPGA. A host walks the window with 32-bit reads. It first finds a fixed identification header, then a packed list of four-word module descriptors. A single all-ones word marks the end of the list. The window ignores writes and only notes them in a sticky error flag.

The header values (revision, model, minor, name) are build-time parameters. The descriptor contents arrive on flat per-slot input vectors. A separate count input says how many slots are populated. The slave port takes a word address, a read strobe and a write strobe, and answers with an ack one clock later. Read data is registered, so it is valid during the ack cycle. A read past the table's end returns all ones. A read past the window returns zero.

Top module: `enum_table_rsp`

## Requirements
- R1: Every clock with `bus_rd` or `bus_wr` high is answered by `bus_ack` high in the next clock. A clock with neither strobe is followed by `bus_ack` low.
- R2: The word at byte 0x00 reads `{bus_type=8'h00, minor, model, revision}`. Revision is in bits 7:0, model in 15:8, minor in 23:16, and the bus type (0) in 31:24. The defaults give 0x0000_4101.
- R3: The word at byte 0x04 reads 0x0000_ABCE: the identifier is in bits 15:0 and the upper half is zero.
- R4: Bytes 0x08 to 0x13 hold a 12-character name with no terminator. Character 0 is in bits 7:0 of the word at 0x08, and each later character takes the next byte, little-endian.
- R5: Slot s occupies bytes 0x14+16*s to 0x23+16*s. Its words, in order, are ID word 1, ID word 2, module offset and module size, taken from bits 32*s+31:32*s of the matching input vector.
- R6: A read that lands in a slot whose index is at or above `slot_count` returns 0xFFFF_FFFF.
- R7: A read at byte 0x200 or above returns zero.
- R8: A write has no effect on any value read back. It sets `wr_err` in the clock after the strobe, and `wr_err` stays set until reset.
- R9: `bus_rdata` keeps its value in every clock that follows a clock without `bus_rd`.
- R10: While reset is asserted, `bus_ack`, `wr_err` and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (data ignored) |
| bus_ack | output | 1 | Access acknowledge, one clock after a strobe |
| bus_rdata | output | 32 | Registered read data |
| wr_err | output | 1 | Sticky flag: a write was attempted |
| slot_count | input | CNT_W | Number of populated descriptor slots |
| slot_id1 | input | 32*NSLOT | ID word 1 of every slot |
| slot_id2 | input | 32*NSLOT | ID word 2 of every slot |
| slot_off | input | 32*NSLOT | Module offset of every slot |
| slot_size | input | 32*NSLOT | Module size of every slot |

## Verification
The table walk runs with five populated slots. Every slot input carries a value that encodes both its slot number and its word kind. A swapped word, a wrong slot stride or an off-by-one at the 20-byte base therefore produces a visibly wrong value. The header words use distinct, asymmetric bytes, so byte-order and field-position errors in the name and identification words show up. Three settings of the populated count are tried: zero, five and full. Together they separate the terminator boundary from the window limit. The slot that straddles 0x200 tells the two apart. Writes to descriptor and header words followed by read-back show that writes are truly ignored.

// File: rtl/enum_table_rsp.sv
module enum_table_rsp #(
  parameter int          ADDR_W = 12,
  parameter int          NSLOT  = 32,
  parameter int          CNT_W  = $clog2(NSLOT + 1),
  parameter logic [7:0]  REV    = 8'd1,
  parameter logic [7:0]  MODEL  = 8'h41,
  parameter logic [7:0]  MINOR  = 8'h00,
  parameter logic [95:0] NAME   = "DISCOVERY_01"
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:2]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  output logic                  bus_ack,
  output logic [31:0]           bus_rdata,
  output logic                  wr_err,
  input  logic [CNT_W-1:0]      slot_count,
  input  logic [32*NSLOT-1:0]   slot_id1,
  input  logic [32*NSLOT-1:0]   slot_id2,
  input  logic [32*NSLOT-1:0]   slot_off,
  input  logic [32*NSLOT-1:0]   slot_size
);
  localparam int WIN_WORDS = 512 / 4;
  localparam int HDR_WORDS = 20 / 4;
  localparam int WA_W      = ADDR_W - 2;
  localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [WA_W-1:0]  doff;
  logic [WA_W-3:0]  slot_idx;
  logic [SLOT_W-1:0] slot_sel;
  logic [31:0]      rd_word;
  logic [31:0]      name_word;

  assign doff     = bus_addr - WA_W'(HDR_WORDS);
  assign slot_idx = doff[WA_W-1:2];
  assign slot_sel = slot_idx[SLOT_W-1:0];

  always_comb begin
    int base;
    base = (int'(bus_addr[4:2]) - 2) * 4;
    name_word = '0;
    if (base >= 0 && base <= 8)
      for (int b = 0; b < 4; b++)
        name_word[b*8 +: 8] = NAME[95 - 8*(base + b) -: 8];
  end

  always_comb begin
    rd_word = '0;
    if (int'(bus_addr) >= WIN_WORDS) begin
      rd_word = '0;
    end else if (int'(bus_addr) < HDR_WORDS) begin
      case (bus_addr[4:2])
        3'd0:    rd_word = {8'h00, MINOR, MODEL, REV};
        3'd1:    rd_word = 32'h0000_ABCE;
        default: rd_word = name_word;
      endcase
    end else if (int'(slot_idx) >= int'(slot_count) || int'(slot_idx) >= NSLOT) begin
      rd_word = 32'hFFFF_FFFF;
    end else begin
      case (doff[1:0])
        2'd0:    rd_word = slot_id1 [32*slot_sel +: 32];
        2'd1:    rd_word = slot_id2 [32*slot_sel +: 32];
        2'd2:    rd_word = slot_off [32*slot_sel +: 32];
        default: rd_word = slot_size[32*slot_sel +: 32];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      bus_ack <= bus_rd | bus_wr;
      wr_err  <= wr_err | bus_wr;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/enum_table_rsp_chk.sv
module enum_table_rsp_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:2] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic [31:0]       bus_rdata,
  input logic              wr_err
);
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_ack); // R1
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bus_ack); // R1
  AST_MAGIC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == 1) |=> bus_rdata == 32'h0000_ABCE); // R3
  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) >= 128) |=> bus_rdata == 32'h0); // R7
  AST_ERR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> wr_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

bind enum_table_rsp enum_table_rsp_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .wr_err(wr_err)
);

// File: tb/enum_table_rsp_tb_top.sv
`timescale 1ns/1ps
module enum_table_rsp_tb_top;
  localparam int ADDR_W = 12;
  localparam int NSLOT  = 32;
  localparam int CNT_W  = $clog2(NSLOT + 1);

  logic clk = 0, rst_n = 0, bus_rd = 0, bus_wr = 0;
  logic [ADDR_W-1:2] bus_addr = '0;
  logic bus_ack, wr_err;
  logic [31:0] bus_rdata;
  logic [CNT_W-1:0] slot_count = 5;
  logic [32*NSLOT-1:0] slot_id1, slot_id2, slot_off, slot_size;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  enum_table_rsp #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .wr_err(wr_err),
    .slot_count(slot_count), .slot_id1(slot_id1), .slot_id2(slot_id2),
    .slot_off(slot_off), .slot_size(slot_size));

  initial
    for (int s = 0; s < NSLOT; s++) begin
      slot_id1 [32*s +: 32] = 32'hA000_0000 + 32'(s);
      slot_id2 [32*s +: 32] = 32'hB000_0000 + 32'(s);
      slot_off [32*s +: 32] = 32'h0001_0000 * 32'(s + 1);
      slot_size[32*s +: 32] = 32'h0000_0100 * 32'(s + 1);
    end

  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {12'h000, 32'h0000_4101},   // R2
    {12'h004, 32'h0000_ABCE},   // R3
    {12'h008, 32'h4353_4944},   // R4 "DISC"
    {12'h00C, 32'h5245_564F},   // R4 "OVER"
    {12'h010, 32'h3130_5F59},   // R4 "Y_01"
    {12'h014, 32'hA000_0000},   // R5
    {12'h018, 32'hB000_0000},   // R5
    {12'h01C, 32'h0001_0000},   // R5
    {12'h020, 32'h0000_0100},   // R5
    {12'h024, 32'hA000_0001},   // R5
    {12'h054, 32'hA000_0004},   // R5
    {12'h060, 32'h0000_0500},   // R5
    {12'h064, 32'hFFFF_FFFF},   // R6
    {12'h1FC, 32'hFFFF_FFFF},   // R6
    {12'h200, 32'h0000_0000},   // R7
    {12'hFFC, 32'h0000_0000}    // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic ak);
    @(negedge clk);
    bus_addr = a[11:2]; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; d = bus_rdata; ak = bus_ack;
  endtask

  task automatic wr(input logic [11:0] a, output logic ak);
    @(negedge clk);
    bus_addr = a[11:2]; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; ak = bus_ack;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, d0;
    logic ak;
    repeat (3) @(negedge clk);
    chk("R10 ack in reset", 32'(bus_ack), 0);
    chk("R10 err in reset", 32'(wr_err), 0);
    chk("R10 rdata in reset", bus_rdata, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][43:32], d, ak);
      chk("R1 read ack", 32'(ak), 1);
      chk($sformatf("R2-table addr %03h", VEC[i][43:32]), d, VEC[i][31:0]);
    end

    @(negedge clk);
    chk("R1 no ack when idle", 32'(bus_ack), 0);
    rd(12'h024, d0, ak);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", bus_rdata, d0);

    wr(12'h014, ak);
    chk("R1 write ack", 32'(ak), 1);
    chk("R8 err set", 32'(wr_err), 1);
    wr(12'h000, ak);
    rd(12'h014, d, ak);
    chk("R8 descriptor unchanged", d, 32'hA000_0000);
    rd(12'h000, d, ak);
    chk("R8 header unchanged", d, 32'h0000_4101);
    repeat (4) @(negedge clk);
    chk("R8 err sticky", 32'(wr_err), 1);

    slot_count = 0;
    rd(12'h014, d, ak);
    chk("R6 empty table terminator", d, 32'hFFFF_FFFF);
    slot_count = 32;
    rd(12'h1F4, d, ak);
    chk("R5 slot 30 id1", d, 32'hA000_001E);
    rd(12'h1FC, d, ak);
    chk("R5 slot 30 offset", d, 32'h001F_0000);
    rd(12'h200, d, ak);
    chk("R7 window end with full table", d, 0);
    slot_count = 5;
    rd(12'h058, d, ak);
    chk("R5 last populated slot id2", d, 32'hB000_0004);
    rd(12'h068, d, ak);
    chk("R6 first empty slot id2", d, 32'hFFFF_FFFF);

    @(negedge clk);
    bus_addr = 0; bus_rd = 1;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    bus_rd = 0;
    chk("R10 reset clears ack", 32'(bus_ack), 0);
    chk("R10 reset clears err", 32'(wr_err), 0);
    finish_run();
  end
endmodule